// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

This block is a synthesizable, clocked model of a word-wide static RAM with independent byte lanes. It is meant to stand in for an external asynchronous memory inside a chip-level simulation or an emulation build. The bidirectional data pins are split into a write-data input, a read-data output and one drive-enable per byte lane. A driven lane is one whose enable is high. A lane whose enable is low models a high-impedance pin and reads as zero.

The device is reached through two chip selects, one active low and one active high, together with active-low write and read strobes and one active-low enable per byte lane. All control inputs are sampled on the rising clock edge. A write window is open for as long as the part is selected, the write strobe is low and at least one lane enable is low. The address, data and lane mask seen in the last sampled cycle of the window are stored on the first edge at which any of these strobes is seen inactive. Reads are combinational from the storage array.

A status output reports standby whenever either chip select is inactive or both lane enables are off. Storage is cleared by reset, and the default depth is 1024 words.

Top module: `sram_bytelane`

## Requirements
- R1: The device is selected only when `sel_n` is 0 and `sel` is 1. Otherwise `rdata_en` is 0 and `standby` is 1, whatever the other inputs are.
- R2: With both bits of `lane_n` at 1, `standby` is 1 and `rdata_en` is 0. A write strobe given in this state stores nothing.
- R3: In a read (selected, `wr_n`=1, `rd_n`=0), `lane_n[0]`=0 drives `rdata[7:0]` and sets `rdata_en[0]`, and `lane_n[1]`=0 drives `rdata[15:8]` and sets `rdata_en[1]`. A lane whose enable bit is 1 has its `rdata_en` bit at 0 and its `rdata` bits at 0.
- R4: When selected with `wr_n`=1 and `rd_n`=1, `rdata_en` is 0 and `standby` is 0.
- R5: While selected with `wr_n`=0, `rdata_en` is 0 whatever the value of `rd_n`.
- R6: A write stores only the byte lanes whose `lane_n` bit was 0. The other byte of the word keeps its old value.
- R7: The address, data and lane mask stored are those sampled in the last cycle in which select, write strobe and a lane enable were all active. Earlier samples from the same window are discarded. The write takes effect at the first edge where any of `sel_n`, `sel`, `wr_n` or the lane enables is seen inactive.
- R8: After reset every word reads as zero.
- R9: `standby` is 0 whenever the device is selected and at least one lane enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low output enable |
| lane_n | input | LANES | Active-low byte-lane enables; bit 0 is the low byte |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data; zero on lanes that are not driven |
| rdata_en | output | LANES | Per-lane drive enable (1 = driven, 0 = high impedance) |
| standby | output | 1 | High when the device is deselected |

## Verification
On every cycle the assertions check the truth-table relations between the strobes and the per-lane drive enables: the deselect and standby conditions, output-disabled mode, the forced high impedance during writes, and the lane-by-lane enables of a read. They also check that undriven lanes read as zero. What was stored, and when, can only be seen in the bench's scenarios. These are partial-lane writes that leave the other byte alone, windows closed by each of the different strobes, an address change inside an open window, a write attempted with both lanes off, and the cleared contents after reset.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_OFF   = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_decode.sv
module sram_decode
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n,
  input  logic             sel,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [LANES-1:0] lane_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] drive,
  output logic             standby
);
  logic chip_on;
  logic lane_any;

  assign chip_on  = ~sel_n & sel;
  assign lane_any = |(~lane_n);

  always_comb begin
    if (!chip_on || !lane_any) mode = MODE_IDLE;
    else if (!wr_n)            mode = MODE_WRITE;
    else if (!rd_n)            mode = MODE_READ;
    else                       mode = MODE_OFF;
  end

  assign standby = (mode == MODE_IDLE);
  assign drive   = (mode == MODE_READ) ? ~lane_n : '0;
endmodule

// File: rtl/sram_wr_window.sv
module sram_wr_window #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [LANES-1:0]  lane_on,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DW-1:0]     c_data,
  output logic [LANES-1:0]  c_lanes
);
  logic              open_q, open_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0]     data_q, data_d;
  logic [LANES-1:0]  lanes_q, lanes_d;
  logic              cap_en;

  assign cap_en = win_on;

  always_comb begin
    open_d  = win_on;
    addr_d  = addr_q;
    data_d  = data_q;
    lanes_d = lanes_q;
    if (cap_en) begin
      addr_d  = addr;
      data_d  = wdata;
      lanes_d = lane_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      lanes_q <= '0;
    end else begin
      open_q  <= open_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      lanes_q <= lanes_d;
    end
  end

  assign commit  = open_q & ~win_on;
  assign c_addr  = addr_q;
  assign c_data  = data_q;
  assign c_lanes = lanes_q;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [LANES-1:0]  wlanes,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rword
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic              lane_we;

    assign lane_we = we & wlanes[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      end else if (lane_we) begin
        bank[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rword[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/sram_bytelane.sv
module sram_bytelane
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    sel,
  input  logic                    wr_n,
  input  logic                    rd_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rdata_en,
  output logic                    standby
);
  localparam int DW = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  sram_mode_e        mode;
  logic [LANES-1:0]  drive;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DW-1:0]     c_data;
  logic [LANES-1:0]  c_lanes;
  logic [DW-1:0]     rword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  sram_decode #(.LANES(LANES)) u_dec (
    .sel_n   (sel_n),
    .sel     (sel),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .lane_n  (lane_n),
    .mode    (mode),
    .drive   (drive),
    .standby (standby)
  );

  sram_wr_window #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .win_on  (mode == MODE_WRITE),
    .addr    (addr),
    .wdata   (wdata),
    .lane_on (~lane_n),
    .commit  (commit),
    .c_addr  (c_addr),
    .c_data  (c_data),
    .c_lanes (c_lanes)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .we     (commit),
    .waddr  (c_addr),
    .wdata  (c_data),
    .wlanes (c_lanes),
    .raddr  (addr),
    .rword  (rword)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign rdata[g*LANE_W +: LANE_W] = drive[g] ? rword[g*LANE_W +: LANE_W] : '0;
  end
  assign rdata_en = drive;
endmodule

// File: rtl/sram_bytelane_chk.sv
module sram_bytelane_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel_n,
  input logic                    sel,
  input logic                    wr_n,
  input logic                    rd_n,
  input logic [LANES-1:0]        lane_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        rdata_en,
  input logic                    standby
);
  logic [LANES*LANE_W-1:0] en_mask;
  always_comb begin
    for (int i = 0; i < LANES; i++)
      en_mask[i*LANE_W +: LANE_W] = {LANE_W{rdata_en[i]}};
  end

  // R1: deselected by either chip select
  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel) |-> (standby && rdata_en == '0));

  // R2: both lanes off means standby with no drive
  a_r2_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_n) |-> (standby && rdata_en == '0));

  // R3: read drives exactly the enabled lanes
  a_r3_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && wr_n && !rd_n) |-> (rdata_en == ~lane_n));

  // R3: undriven lanes read as zero
  a_r3_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~en_mask) == '0));

  // R4: output-disabled mode
  a_r4_out_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && wr_n && rd_n) |-> (rdata_en == '0));

  // R5: no drive while writing
  a_r5_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !wr_n) |-> (rdata_en == '0));

  // R9: active status when selected with a lane on
  a_r9_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !(&lane_n)) |-> !standby);
endmodule

bind sram_bytelane sram_bytelane_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (sel_n),
  .sel      (sel),
  .wr_n     (wr_n),
  .rd_n     (rd_n),
  .lane_n   (lane_n),
  .rdata    (rdata),
  .rdata_en (rdata_en),
  .standby  (standby)
);

// File: tb/tb_sram_bytelane.sv
`timescale 1ns/1ps
module tb_sram_bytelane;
  localparam int ADDR_W = 10;

  logic        clk;
  logic        rst_n;
  logic        sel_n, sel, wr_n, rd_n;
  logic [1:0]  lane_n;
  logic [9:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  rdata_en;
  logic        standby;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sram_bytelane #(.ADDR_W(ADDR_W), .LANES(2), .LANE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .rd_n(rd_n),
    .lane_n(lane_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_en(rdata_en), .standby(standby)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [15:0] tag;
    logic        sel_n, sel, wr_n, rd_n;
    logic [1:0]  lane_n;
    logic [9:0]  addr;
    logic [15:0] wdata;
    logic [1:0]  en;
    logic [15:0] rd;
    logic        sb;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{"R1", 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 10'd5, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{"R1", 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd5, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{"R8", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd5, 16'h0000, 2'b11, 16'h0000, 1'b0},
    '{"R5", 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 10'd5, 16'hA1B2, 2'b00, 16'h0000, 1'b0},
    '{"R4", 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 10'd5, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{"R7", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd5, 16'h0000, 2'b11, 16'hA1B2, 1'b0},
    '{"R5", 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 10'd5, 16'hFFEE, 2'b00, 16'h0000, 1'b0},
    '{"R1", 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 10'd5, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{"R6", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd5, 16'h0000, 2'b11, 16'hA1EE, 1'b0},
    '{"R3", 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 10'd5, 16'h0000, 2'b10, 16'hA100, 1'b0},
    '{"R3", 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 10'd5, 16'h0000, 2'b01, 16'h00EE, 1'b0},
    '{"R2", 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 10'd5, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{"R2", 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 10'd6, 16'h5555, 2'b00, 16'h0000, 1'b1},
    '{"R2", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd6, 16'h0000, 2'b11, 16'h0000, 1'b0},
    '{"R5", 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 10'd7, 16'h1111, 2'b00, 16'h0000, 1'b0},
    '{"R7", 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 10'd8, 16'h2222, 2'b00, 16'h0000, 1'b0},
    '{"R1", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 10'd8, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{"R7", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd7, 16'h0000, 2'b11, 16'h0000, 1'b0},
    '{"R7", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd8, 16'h0000, 2'b11, 16'h2222, 1'b0},
    '{"R9", 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 10'd9, 16'h3333, 2'b00, 16'h0000, 1'b0},
    '{"R2", 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 10'd9, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{"R7", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd9, 16'h0000, 2'b11, 16'h3333, 1'b0}
  };

  task automatic check(input string req, input logic [1:0] e_en,
                       input logic [15:0] e_rd, input logic e_sb);
    checks++;
    if (rdata_en !== e_en || rdata !== e_rd || standby !== e_sb) begin
      fails++;
      $display("FAIL %s: en=%b rdata=%h standby=%b expected en=%b rdata=%h standby=%b",
               req, rdata_en, rdata, standby, e_en, e_rd, e_sb);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic c, input logic d,
                       input logic [1:0] l, input logic [9:0] ad, input logic [15:0] wd);
    sel_n = a; sel = b; wr_n = c; rd_n = d; lane_n = l; addr = ad; wdata = wd;
  endtask

  initial begin
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1", 2'b00, 16'h0000, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].sel_n, TBL[i].sel, TBL[i].wr_n, TBL[i].rd_n,
            TBL[i].lane_n, TBL[i].addr, TBL[i].wdata);
      #1 check(string'(TBL[i].tag), TBL[i].en, TBL[i].rd, TBL[i].sb);
    end

    // R5: write with output enable low, closed by the write strobe
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 10'd3, 16'hBEEF);
    #1 check("R5", 2'b00, 16'h0000, 1'b0);
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 10'd3, 16'h0000);
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd3, 16'h0000);
    #1 check("R6", 2'b11, 16'hBE00, 1'b0);

    // R8: reset mid-run clears stored words
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd5, 16'h0000);
    #1 check("R8", 2'b11, 16'h0000, 1'b0);
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd8, 16'h0000);
    #1 check("R8", 2'b11, 16'h0000, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule